// File: doc/BRIEF.md
# Stationary-Weight Multiply-Accumulate Grid

This block is a small grid of multiply-accumulate cells arranged two rows by two columns. Each cell keeps one weight that stays put while operands stream past it. A signed operand entering a row travels rightward one cell per clock. A running sum starts at zero above each column and travels downward one cell per clock, gaining one product at every cell it passes. The cell at the bottom of each column delivers a finished dot product, with a flag that marks the cycles carrying a complete result. Downstream logic that aligns columns and collects results is not part of this block.

Weights reach the cells through the same column inputs. While the load strobe is held, a phase counter steps through a short sequence. Each column input carries the weight meant for the lower cell first and the weight for the upper cell one cycle later. Each column latches both of its cells together at its own phase, and the right column runs one cycle behind the left. Row 1 operands must be presented one cycle after the matching row 0 operand, so that they meet the partial sum coming down from above.

Top module: `ws_mac_grid`

## Requirements
- R1: A synchronous active-high `rst` clears every stored weight, operand register, partial sum and flag. In the cycle after a reset edge, both `psum_o` columns and both `psum_vld_o` bits are zero. A vector streamed after reset with no load yields a result of 0.
- R2: A load runs while `w_load_i` is high, with phases 0, 1, 2 counted from the first high cycle. Phase 0: column 0 carries weight W[1][0]. Phase 1: column 0 carries W[0][0], column 1 carries W[1][1], and column 0 latches both its cells. Phase 2: column 1 carries W[0][1] and column 1 latches both its cells. A latched weight takes effect from the cycle after its phase.
- R3: While `w_load_i` stays high, the phase wraps from 2 back to 0, so loads can follow back to back. Any low cycle returns the phase to 0. A load cut short after phase 1 therefore updates column 0 only.
- R4: Outside its capture phase, a weight holds its value for any number of idle or streaming cycles, whatever is on the column inputs.
- R5: Each column delivers the sum over rows r of x[r]*W[r][c]. Operands and weights are signed 8-bit. The sum is signed 32-bit two's complement and is never saturated.
- R6: If row 0 is valid in cycle t and row 1 is valid in cycle t+1, column c shows the result with `psum_vld_o[c]` high in cycle t+2+c.
- R7: `psum_vld_o[c]` is high only when both row contributions of that vector were valid with the one-cycle skew. A row 1 operand without its row 0 partner, or a row 0 operand without its row 1 partner, produces no valid result.
- R8: A multiply that a cell performs in the same cycle as that cell's capture uses the old weight. The new weight applies from the next cycle.
- R9: The extreme products (-128)*(-128) and (-128)*127 come out exactly, including their sums across rows.
- R10: Vectors may enter on every cycle. Each column then produces one valid result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| w_load_i | input | 1 | Weight load strobe, stepping the load phase |
| w_col_i | input | 16 | Column weight inputs, column c in bits [8c+7:8c], signed |
| act_i | input | 16 | Row operands, row r in bits [8r+7:8r], signed |
| act_vld_i | input | 2 | Row operand valid, bit r for row r |
| psum_o | output | 64 | Column results, column c in bits [32c+31:32c], signed |
| psum_vld_o | output | 2 | Column result valid, bit c for column c |

## Verification
A weight capture and a multiply in the same cell can occur in one cycle. The bench provokes this by running a reload while back-to-back vectors are streaming, so every phase of the load lands on a cell that is busy multiplying. The cycle-accurate model in the bench tracks which weight is in force in each cycle. It uses the old weight for a product formed in its capture cycle and the new one afterwards. Every valid result is compared against that model, so a cell that switches weights one cycle early or late shows up as a wrong sum.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int unsigned WS_DATA_W = 8;
    localparam int unsigned WS_ACC_W  = 32;
endpackage

// File: rtl/ws_load_seq.sv
module ws_load_seq #(
    parameter int unsigned ROWS = 2,
    parameter int unsigned COLS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    output logic [COLS-1:0] cap_o
);
    localparam int unsigned PH_N = ROWS + COLS - 1;
    localparam int unsigned PH_W = (PH_N > 1) ? $clog2(PH_N) : 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.ph = (q.ph == PH_W'(PH_N - 1)) ? '0 : q.ph + 1'b1;
        end else begin
            d.ph = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_cap
        assign cap_o[c] = load_i && (q.ph == PH_W'(c + ROWS - 1));
    end

    p_single_cap_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap_o));
    p_cap_needs_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_o != '0) |-> load_i);
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (q.ph == '0));
    p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
        q.ph <= PH_W'(PH_N - 1));
endmodule

// File: rtl/ws_pe.sv
module ws_pe #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] a_i,
    input  logic                 av_i,
    input  logic signed [AW-1:0] p_i,
    input  logic                 pv_i,
    input  logic signed [DW-1:0] w_i,
    input  logic                 cap_i,
    output logic signed [DW-1:0] a_o,
    output logic                 av_o,
    output logic signed [AW-1:0] p_o,
    output logic                 pv_o,
    output logic signed [DW-1:0] wp_o
);
    typedef struct packed {
        logic signed [DW-1:0] w;
        logic signed [DW-1:0] wp;
        logic signed [DW-1:0] a;
        logic                 av;
        logic signed [AW-1:0] p;
        logic                 pv;
    } pe_t;

    pe_t q, d;
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;

    always_comb begin
        prod     = a_i * q.w;
        prod_ext = av_i ? {{(AW-2*DW){prod[2*DW-1]}}, prod} : '0;
        d        = q;
        d.wp     = w_i;
        if (cap_i) d.w = w_i;
        d.a      = av_i ? a_i : '0;
        d.av     = av_i;
        d.p      = p_i + prod_ext;
        d.pv     = av_i & pv_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign a_o  = q.a;
    assign av_o = q.av;
    assign p_o  = q.p;
    assign pv_o = q.pv;
    assign wp_o = q.wp;

    p_hold_weight_r4: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(q.w));
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (q.w == $past(w_i)));
    p_idle_pass_r7: assert property (@(posedge clk) disable iff (rst)
        !av_i |=> (p_o == $past(p_i)));
    p_valid_hop_r7: assert property (@(posedge clk) disable iff (rst)
        pv_o |-> $past(av_i));
endmodule

// File: rtl/ws_mac_grid.sv
module ws_mac_grid
    import ws_pkg::*;
#(
    parameter int unsigned ROWS   = 2,
    parameter int unsigned COLS   = 2,
    parameter int unsigned DATA_W = WS_DATA_W,
    parameter int unsigned ACC_W  = WS_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    w_load_i,
    input  logic [COLS*DATA_W-1:0]  w_col_i,
    input  logic [ROWS*DATA_W-1:0]  act_i,
    input  logic [ROWS-1:0]         act_vld_i,
    output logic [COLS*ACC_W-1:0]   psum_o,
    output logic [COLS-1:0]         psum_vld_o
);
    logic signed [DATA_W-1:0] a_h  [ROWS][COLS+1];
    logic                     av_h [ROWS][COLS+1];
    logic signed [ACC_W-1:0]  p_v  [ROWS+1][COLS];
    logic                     pv_v [ROWS+1][COLS];
    logic signed [DATA_W-1:0] w_v  [ROWS+1][COLS];
    logic [COLS-1:0]          cap;

    ws_load_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .load_i (w_load_i),
        .cap_o  (cap)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row_in
        assign a_h[r][0]  = act_i[r*DATA_W +: DATA_W];
        assign av_h[r][0] = act_vld_i[r];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col_io
        assign p_v[0][c]  = '0;
        assign pv_v[0][c] = 1'b1;
        assign w_v[0][c]  = w_col_i[c*DATA_W +: DATA_W];
        assign psum_o[c*ACC_W +: ACC_W] = p_v[ROWS][c];
        assign psum_vld_o[c]            = pv_v[ROWS][c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            ws_pe #(.DW(DATA_W), .AW(ACC_W)) u_pe (
                .clk   (clk),
                .rst   (rst),
                .a_i   (a_h[r][c]),
                .av_i  (av_h[r][c]),
                .p_i   (p_v[r][c]),
                .pv_i  (pv_v[r][c]),
                .w_i   (w_v[r][c]),
                .cap_i (cap[c]),
                .a_o   (a_h[r][c+1]),
                .av_o  (av_h[r][c+1]),
                .p_o   (p_v[r+1][c]),
                .pv_o  (pv_v[r+1][c]),
                .wp_o  (w_v[r+1][c])
            );
        end
    end

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> (psum_vld_o == '0 && psum_o == '0));
    p_bottom_needs_row_r7: assert property (@(posedge clk) disable iff (rst)
        psum_vld_o[0] |-> $past(act_vld_i[ROWS-1]));
endmodule

// File: tb/ws_mac_grid_tb.sv
module ws_mac_grid_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        w_load_i = 1'b0;
    logic [15:0] w_col_i = '0;
    logic [15:0] act_i = '0;
    logic [1:0]  act_vld_i = '0;
    logic [63:0] psum_o;
    logic [1:0]  psum_vld_o;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    ws_mac_grid u_dut (
        .clk(clk), .rst(rst), .w_load_i(w_load_i), .w_col_i(w_col_i),
        .act_i(act_i), .act_vld_i(act_vld_i), .psum_o(psum_o), .psum_vld_o(psum_vld_o)
    );

    // behavioural history, one entry per cycle
    bit rs [1024];
    bit wl [1024];
    int win [1024][2];
    bit av [1024][2];
    int ai [1024][2];
    int ph [1024];
    int weff [1025][2][2];
    int cyc = 0;
    int lr = -1;

    initial begin
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 2; c++) weff[0][r][c] = 0;
    end

    always @(negedge clk) begin
        if (!done && cyc < 1023) begin
            int k;
            k = cyc;
            rs[k] = rst;
            wl[k] = w_load_i;
            for (int c = 0; c < 2; c++) win[k][c] = int'($signed(w_col_i[c*8 +: 8]));
            for (int r = 0; r < 2; r++) begin
                av[k][r] = act_vld_i[r];
                ai[k][r] = int'($signed(act_i[r*8 +: 8]));
            end
            ph[k] = (k > 0 && wl[k-1] && !rs[k-1]) ? (ph[k-1] + 1) % 3 : 0;
            for (int c = 0; c < 2; c++) begin
                int j0, j1, ed, got;
                bit ev;
                j0 = k - 2 - c;
                j1 = k - 1 - c;
                ev = (j0 > lr) && (j0 >= 0) && av[j0][0] && av[j1][1];
                ed = ev ? ai[j0][0] * weff[k-2][0][c] + ai[j1][1] * weff[k-1][1][c] : 0;
                got = int'($signed(psum_o[c*32 +: 32]));
                n_chk++;
                if (psum_vld_o[c] !== ev) begin
                    n_bad++;
                    $display("FAIL %s cyc %0d col%0d valid got %0d exp %0d", tag, k, c, psum_vld_o[c], ev);
                end
                if (ev || (k >= 1 && rs[k-1])) begin
                    n_chk++;
                    if (got != ed) begin
                        n_bad++;
                        $display("FAIL %s cyc %0d col%0d sum got %0d exp %0d", tag, k, c, got, ed);
                    end
                end
            end
            for (int r = 0; r < 2; r++)
                for (int c = 0; c < 2; c++) weff[k+1][r][c] = rs[k] ? 0 : weff[k][r][c];
            if (!rs[k]) begin
                for (int c = 0; c < 2; c++) begin
                    if (wl[k] && ph[k] == c + 1) begin
                        weff[k+1][0][c] = win[k][c];
                        weff[k+1][1][c] = (k > 0) ? win[k-1][c] : 0;
                    end
                end
            end
            if (rst) lr = k;
            cyc++;
        end
    end

    task automatic drv(input bit r, input bit l, input int w0, input int w1,
                       input bit v0, input int a0, input bit v1, input int a1);
        @(posedge clk);
        #2;
        rst       = r;
        w_load_i  = l;
        w_col_i   = {8'(w1), 8'(w0)};
        act_vld_i = {v1, v0};
        act_i     = {8'(a1), 8'(a0)};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(0, 0, 55, -66, 0, 0, 0, 0);
    endtask

    task automatic load(input int w00, input int w01, input int w10, input int w11);
        drv(0, 1, w10, 99, 0, 0, 0, 0);
        drv(0, 1, w00, w11, 0, 0, 0, 0);
        drv(0, 1, 77, w01, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // n back-to-back vectors with row 1 skewed by one cycle
    task automatic stream(input int n, input int seed);
        for (int i = 0; i <= n; i++)
            drv(0, 0, 0, 0, i < n, ((seed + i * 37) % 256) - 128,
                i >= 1, ((seed + i * 53 + 11) % 256) - 128);
        idle(3);
    endtask

    initial begin
        tag = "R1";
        drv(1, 0, 0, 0, 1, 9, 1, 9);
        drv(1, 0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 0);
        stream(2, 5);
        tag = "R2";
        load(1, 2, 3, 4);
        tag = "R5";
        drv(0, 0, 0, 0, 1, 5, 0, 0);
        drv(0, 0, 0, 0, 1, 6, 1, 7);
        drv(0, 0, 0, 0, 0, 0, 1, 8);
        tag = "R6";
        idle(4);
        tag = "R10";
        stream(6, 17);
        tag = "R4";
        idle(7);
        stream(3, 90);
        tag = "R9";
        load(-128, 127, -128, -1);
        drv(0, 0, 0, 0, 1, -128, 0, 0);
        drv(0, 0, 0, 0, 1, 127, 1, -128);
        drv(0, 0, 0, 0, 1, -128, 1, -128);
        drv(0, 0, 0, 0, 0, 0, 1, 127);
        idle(4);
        tag = "R8";
        for (int i = 0; i < 10; i++) begin
            bit l;
            int w0, w1;
            l  = (i >= 2 && i <= 4);
            w0 = (i == 2) ? 5 : (i == 3) ? 2 : 44;
            w1 = (i == 3) ? 7 : (i == 4) ? -3 : 33;
            drv(0, l, w0, w1, i < 9, i * 11 - 40, i >= 1, 60 - i * 9);
        end
        idle(4);
        tag = "R3";
        for (int i = 0; i < 6; i++) drv(0, 1, 10 + i, -20 - i, 0, 0, 0, 0);
        stream(3, 40);
        drv(0, 1, 21, 22, 0, 0, 0, 0);
        drv(0, 1, 23, 24, 0, 0, 0, 0);
        drv(0, 0, 25, 26, 0, 0, 0, 0);
        stream(3, 71);
        tag = "R7";
        drv(0, 0, 0, 0, 0, 0, 1, 9);
        drv(0, 0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 4, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 3, 0, 0);
        drv(0, 0, 0, 0, 1, 2, 1, 6);
        idle(5);
        tag = "R1";
        drv(0, 0, 0, 0, 1, 50, 0, 0);
        drv(0, 0, 0, 0, 1, 51, 1, 52);
        drv(1, 0, 0, 0, 1, 53, 1, 54);
        drv(0, 0, 0, 0, 0, 0, 1, 55);
        idle(3);
        stream(3, 123);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (tag %s) got hang exp finish", tag);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule